// File: doc/BRIEF.md
# Programmable Pixel Colour Component Extractor

This block sits between a pixel fetch buffer and a display output. It takes one raw pixel word of one to four bytes each cycle and returns an 8-bit red, green and blue value together with a data-enable strobe. A format word sets how many bytes of the pixel word are meaningful. Three per-channel select words set where each colour component lies inside the pixel, so one datapath can serve packed 8-bit, 16-bit, 24-bit and 32-bit pixel layouts.

Each channel extracts a bit field given by its lowest bit index and its length. The field is widened to eight bits by replicating its top bits, so a full-scale field gives full-scale output. Each channel also holds a default colour. The default replaces the extracted value when the channel's length is zero, when the pixel lies outside the visible area, or when the fetch buffer cannot supply the pixel. A red default of 0xFF therefore shows buffer starvation as red.

All outputs come from registers and appear one clock after the inputs.

Top module: `pix_comp_extract`

## Requirements
- R1: The format word carries bytes-per-pixel minus one in bits [4:3], so 0 means one byte and 3 means four bytes. The other bits of the format word are ignored. Pixel bytes at or above the configured count read as zero.
- R2: Each select word holds the channel default in bits [23:16], the field length in bits [11:8] and the lowest bit index in bits [4:0]. All other bits are ignored.
- R3: With an 8-bit length, a channel outputs pixel bits [lsb+7:lsb] of the masked pixel word. Positions beyond bit 31 read as zero.
- R4: A field of length L, with L from 1 to 7, is placed in the top L output bits. Each remaining lower output bit copies the bit L places above it. For example, the 5-bit field 10100 gives 0xA5 and the 1-bit field 1 gives 0xFF.
- R5: A length from 9 to 15 behaves exactly like a length of 8.
- R6: A channel whose length is zero outputs its default colour, whatever the pixel word holds.
- R7: When active_i is low, all three channels output their defaults.
- R8: When active_i is high and underrun_i is high or pix_valid_i is low, all three channels output their defaults.
- R9: Colour outputs and de_o change only at a rising clock edge, one cycle after their inputs. de_o equals active_i delayed by one cycle.
- R10: While rst_ni is low, all colour outputs are zero and de_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_cfg_i | input | 32 | Format word; bytes per pixel minus one in [4:3] |
| red_sel_i | input | 32 | Red select word: default, length and lowest bit |
| grn_sel_i | input | 32 | Green select word |
| blu_sel_i | input | 32 | Blue select word |
| pix_i | input | 32 | Raw pixel word from the fetch buffer |
| pix_valid_i | input | 1 | pix_i holds a fetched pixel |
| active_i | input | 1 | Current pixel lies in the visible area |
| underrun_i | input | 1 | Fetch buffer has run dry |
| red_o | output | 8 | Red component, registered |
| grn_o | output | 8 | Green component, registered |
| blu_o | output | 8 | Blue component, registered |
| de_o | output | 1 | Data enable, active_i delayed by one cycle |

## Verification
The assertions assume that the select words and the format word are static configuration. They may change only between pixels and are sampled in the same cycle as the pixel they apply to. The assertions also assume that active_i, pix_valid_i and underrun_i are clean levels at each rising edge. The stimulus changes every input, configuration included, only on the falling edge. Each configuration is applied together with its pixel, so every property compares an output against the inputs of exactly one earlier cycle.

// File: rtl/pix_ext_pkg.sv
package pix_ext_pkg;

  localparam int SEL_DFLT_LSB = 16;
  localparam int SEL_LEN_LSB  = 8;
  localparam int SEL_IDX_LSB  = 0;
  localparam int FMT_BPP_LSB  = 3;

  typedef struct packed {
    logic [7:0] dflt;
    logic [3:0] len;
    logic [4:0] lsb;
  } chan_cfg_t;

  function automatic chan_cfg_t decode_sel(input logic [31:0] w);
    chan_cfg_t c;
    c.dflt = w[SEL_DFLT_LSB +: 8];
    c.len  = w[SEL_LEN_LSB  +: 4];
    c.lsb  = w[SEL_IDX_LSB  +: 5];
    return c;
  endfunction

endpackage

// File: rtl/pix_byte_mask.sv
module pix_byte_mask #(
  parameter int PIX_BYTES = 4,
  localparam int BPP_W    = (PIX_BYTES > 1) ? $clog2(PIX_BYTES) : 1,
  localparam int PIX_W    = PIX_BYTES * 8
) (
  input  logic [BPP_W-1:0] bpp_m1_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [PIX_W-1:0] pix_o
);

  for (genvar b = 0; b < PIX_BYTES; b++) begin : g_byte
    localparam logic [BPP_W-1:0] IDX = BPP_W'(b);
    assign pix_o[b*8 +: 8] = (IDX <= bpp_m1_i) ? pix_i[b*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/pix_field_extract.sv
module pix_field_extract #(
  parameter int PIX_W  = 32,
  parameter int COMP_W = 8,
  parameter int LEN_W  = 4,
  localparam int IDX_W = $clog2(PIX_W)
) (
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [IDX_W-1:0]  lsb_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [COMP_W-1:0] comp_o,
  output logic              len_zero_o
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(COMP_W);

  logic [LEN_W-1:0]  eff_len;
  logic [PIX_W-1:0]  shifted;
  logic [COMP_W-1:0] raw;
  logic [COMP_W-1:0] cand [COMP_W+1];

  // clamp long fields to the component width
  assign eff_len    = (len_i > LEN_MAX) ? LEN_MAX : len_i;
  assign shifted    = pix_i >> lsb_i;
  assign raw        = shifted[COMP_W-1:0];
  assign len_zero_o = (len_i == '0);

  assign cand[0] = '0;

  // one constant wiring per field length: msb-align, repeat top bits downward
  for (genvar l = 1; l <= COMP_W; l++) begin : g_len
    for (genvar i = 0; i < COMP_W; i++) begin : g_bit
      assign cand[l][COMP_W-1-i] = raw[l-1-(i % l)];
    end
  end

  always_comb begin
    comp_o = '0;
    for (int l = 0; l <= COMP_W; l++) begin
      if (eff_len == LEN_W'(l)) comp_o = cand[l];
    end
  end

endmodule

// File: rtl/pix_comp_extract.sv
module pix_comp_extract
  import pix_ext_pkg::*;
#(
  parameter int PIX_BYTES = 4,
  parameter int COMP_W    = 8,
  parameter int N_CHAN    = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] fmt_cfg_i,
  input  logic [31:0] red_sel_i,
  input  logic [31:0] grn_sel_i,
  input  logic [31:0] blu_sel_i,
  input  logic [31:0] pix_i,
  input  logic        pix_valid_i,
  input  logic        active_i,
  input  logic        underrun_i,
  output logic [7:0]  red_o,
  output logic [7:0]  grn_o,
  output logic [7:0]  blu_o,
  output logic        de_o
);

  localparam int PIX_W = PIX_BYTES * 8;
  localparam int BPP_W = (PIX_BYTES > 1) ? $clog2(PIX_BYTES) : 1;
  localparam int IDX_W = $clog2(PIX_W);

  logic [BPP_W-1:0]  bpp_m1;
  logic [PIX_W-1:0]  pix_masked;
  logic [31:0]       sel_w   [N_CHAN];
  chan_cfg_t         cfg     [N_CHAN];
  logic [COMP_W-1:0] comp    [N_CHAN];
  logic              len_zero[N_CHAN];
  logic [COMP_W-1:0] comp_d  [N_CHAN];
  logic [COMP_W-1:0] comp_q  [N_CHAN];
  logic              force_dflt;
  logic              de_q;

  assign bpp_m1 = fmt_cfg_i[FMT_BPP_LSB +: BPP_W];

  assign sel_w[0] = red_sel_i;
  assign sel_w[1] = grn_sel_i;
  assign sel_w[2] = blu_sel_i;

  // pixel unusable: off-screen, starved, or not yet fetched
  assign force_dflt = !active_i || underrun_i || !pix_valid_i;

  pix_byte_mask #(
    .PIX_BYTES(PIX_BYTES)
  ) u_mask (
    .bpp_m1_i(bpp_m1),
    .pix_i   (pix_i[PIX_W-1:0]),
    .pix_o   (pix_masked)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    assign cfg[c] = decode_sel(sel_w[c]);

    pix_field_extract #(
      .PIX_W (PIX_W),
      .COMP_W(COMP_W),
      .LEN_W (4)
    ) u_ext (
      .pix_i     (pix_masked),
      .lsb_i     (cfg[c].lsb[IDX_W-1:0]),
      .len_i     (cfg[c].len),
      .comp_o    (comp[c]),
      .len_zero_o(len_zero[c])
    );

    assign comp_d[c] = (force_dflt || len_zero[c]) ? cfg[c].dflt[COMP_W-1:0] : comp[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) comp_q[c] <= '0;
      else         comp_q[c] <= comp_d[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) de_q <= 1'b0;
    else         de_q <= active_i;
  end

  assign red_o = comp_q[0];
  assign grn_o = comp_q[1];
  assign blu_o = comp_q[2];
  assign de_o  = de_q;

endmodule

// File: rtl/pix_comp_extract_chk.sv
module pix_comp_extract_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] red_sel_i,
  input logic [31:0] grn_sel_i,
  input logic [31:0] blu_sel_i,
  input logic [31:0] pix_i,
  input logic        pix_valid_i,
  input logic        active_i,
  input logic        underrun_i,
  input logic [7:0]  red_o,
  input logic [7:0]  grn_o,
  input logic [7:0]  blu_o,
  input logic        de_o
);

  // R7
  offscreen_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (red_o == $past(red_sel_i[23:16]) && grn_o == $past(grn_sel_i[23:16])
                   && blu_o == $past(blu_sel_i[23:16])));

  // R8
  starve_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && (underrun_i || !pix_valid_i)) |=>
      (red_o == $past(red_sel_i[23:16]) && grn_o == $past(grn_sel_i[23:16])
       && blu_o == $past(blu_sel_i[23:16])));

  // R6
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grn_sel_i[11:8] == 4'd0) |=> grn_o == $past(grn_sel_i[23:16]));

  // R9
  de_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> de_o == $past(active_i));

  // R5
  low_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && pix_valid_i && !underrun_i && red_sel_i[11:8] >= 4'd8
     && red_sel_i[4:0] == 5'd0) |=> red_o == $past(pix_i[7:0]));

endmodule

bind pix_comp_extract pix_comp_extract_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .red_sel_i  (red_sel_i),
  .grn_sel_i  (grn_sel_i),
  .blu_sel_i  (blu_sel_i),
  .pix_i      (pix_i),
  .pix_valid_i(pix_valid_i),
  .active_i   (active_i),
  .underrun_i (underrun_i),
  .red_o      (red_o),
  .grn_o      (grn_o),
  .blu_o      (blu_o),
  .de_o       (de_o)
);

// File: tb/pix_comp_extract_tb_top.sv
module pix_comp_extract_tb_top;

  function automatic logic [31:0] mk_sel(input logic [7:0] d, input logic [3:0] len,
                                         input logic [4:0] lsb);
    // junk in unused bits checks that they are ignored (R2)
    return {8'hC3, d, 4'hA, len, 3'b110, lsb};
  endfunction

  typedef struct packed {
    logic [1:0]  bpp_m1;
    logic [31:0] rsel;
    logic [31:0] gsel;
    logic [31:0] bsel;
    logic [31:0] pix;
    logic        act;
    logic        vld;
    logic        und;
    logic [7:0]  er;
    logic [7:0]  eg;
    logic [7:0]  eb;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    // R1 R2 R3: three bytes, top byte masked
    '{2'd2, mk_sel(8'h00,4'd8,5'd16), mk_sel(8'h00,4'd8,5'd8), mk_sel(8'h00,4'd8,5'd0),
      32'hAA123456, 1'b1,1'b1,1'b0, 8'h12,8'h34,8'h56},
    // R3: four bytes
    '{2'd3, mk_sel(8'h00,4'd8,5'd24), mk_sel(8'h00,4'd8,5'd16), mk_sel(8'h00,4'd8,5'd8),
      32'h89ABCDEF, 1'b1,1'b1,1'b0, 8'h89,8'hAB,8'hCD},
    // R4: 5/6/5 layout
    '{2'd1, mk_sel(8'h00,4'd5,5'd11), mk_sel(8'h00,4'd6,5'd5), mk_sel(8'h00,4'd5,5'd0),
      32'h0000A5C3, 1'b1,1'b1,1'b0, 8'hA5,8'hBA,8'h18},
    // R1 mask straddle, R6 zero length, R5 clamp 12->8
    '{2'd1, mk_sel(8'h00,4'd8,5'd12), mk_sel(8'h5A,4'd0,5'd0), mk_sel(8'h00,4'd12,5'd0),
      32'h000FF0A7, 1'b1,1'b1,1'b0, 8'h0F,8'h5A,8'hA7},
    // R4: 3/3/2 single byte
    '{2'd0, mk_sel(8'h00,4'd3,5'd5), mk_sel(8'h00,4'd3,5'd2), mk_sel(8'h00,4'd2,5'd0),
      32'hFFFFFF6D, 1'b1,1'b1,1'b0, 8'h6D,8'h6D,8'h55},
    // R4 one-bit field, R1 masked top byte
    '{2'd2, mk_sel(8'h00,4'd1,5'd23), mk_sel(8'h00,4'd1,5'd31), mk_sel(8'h00,4'd8,5'd28),
      32'h80800000, 1'b1,1'b1,1'b0, 8'hFF,8'h00,8'h00},
    // R3 reading past bit 31
    '{2'd3, mk_sel(8'h00,4'd8,5'd28), mk_sel(8'h00,4'd2,5'd31), mk_sel(8'h00,4'd4,5'd0),
      32'hF0000000, 1'b1,1'b1,1'b0, 8'h0F,8'h55,8'h00},
    // R7 off-screen
    '{2'd2, mk_sel(8'hFF,4'd8,5'd16), mk_sel(8'h22,4'd8,5'd8), mk_sel(8'h33,4'd8,5'd0),
      32'h00123456, 1'b0,1'b1,1'b0, 8'hFF,8'h22,8'h33},
    // R8 underrun shows red
    '{2'd2, mk_sel(8'hFF,4'd8,5'd16), mk_sel(8'h22,4'd8,5'd8), mk_sel(8'h33,4'd8,5'd0),
      32'h00123456, 1'b1,1'b1,1'b1, 8'hFF,8'h22,8'h33},
    // R8 no valid pixel
    '{2'd2, mk_sel(8'hFF,4'd8,5'd16), mk_sel(8'h22,4'd8,5'd8), mk_sel(8'h33,4'd8,5'd0),
      32'h00123456, 1'b1,1'b0,1'b0, 8'hFF,8'h22,8'h33}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fmt_cfg_i = '0;
  logic [31:0] red_sel_i = '0;
  logic [31:0] grn_sel_i = '0;
  logic [31:0] blu_sel_i = '0;
  logic [31:0] pix_i = '0;
  logic        pix_valid_i = 1'b0;
  logic        active_i = 1'b0;
  logic        underrun_i = 1'b0;
  logic [7:0]  red_o, grn_o, blu_o;
  logic        de_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pix_comp_extract dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fmt_cfg_i(fmt_cfg_i),
    .red_sel_i(red_sel_i), .grn_sel_i(grn_sel_i), .blu_sel_i(blu_sel_i),
    .pix_i(pix_i), .pix_valid_i(pix_valid_i), .active_i(active_i), .underrun_i(underrun_i),
    .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o), .de_o(de_o)
  );

  task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got rgb/de=%h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    fmt_cfg_i   = {24'h5A0000 >> 0, 3'b000, v.bpp_m1, 3'b111};
    red_sel_i   = v.rsel;
    grn_sel_i   = v.gsel;
    blu_sel_i   = v.bsel;
    pix_i       = v.pix;
    active_i    = v.act;
    pix_valid_i = v.vld;
    underrun_i  = v.und;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10", {red_o, grn_o, blu_o, de_o}, 25'h0);
    rst_ni = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk_i);
      apply(VECS[k]);
      @(negedge clk_i);
      check($sformatf("R3 table vector %0d", k), {red_o, grn_o, blu_o, de_o},
            {VECS[k].er, VECS[k].eg, VECS[k].eb, VECS[k].act});
    end

    // R9 latency: output holds until the edge, then follows
    @(negedge clk_i);
    apply(VECS[1]);
    @(negedge clk_i);
    apply(VECS[0]);
    #1;
    check("R9 hold before edge", {red_o, grn_o, blu_o, de_o}, {8'h89, 8'hAB, 8'hCD, 1'b1});
    @(negedge clk_i);
    check("R9 update after edge", {red_o, grn_o, blu_o, de_o}, {8'h12, 8'h34, 8'h56, 1'b1});

    // R7 de follows active low with one cycle delay
    active_i = 1'b0;
    #1;
    check("R9 de held", {7'd0, 17'd0, de_o}, 25'd1);
    @(negedge clk_i);
    check("R7 de drops", {red_o, grn_o, blu_o, de_o}, {8'h00, 8'h00, 8'h00, 1'b0});

    // R6 zero length on all three, pixel all ones
    active_i  = 1'b1;
    pix_i     = 32'hFFFFFFFF;
    red_sel_i = mk_sel(8'h01, 4'd0, 5'd0);
    grn_sel_i = mk_sel(8'h02, 4'd0, 5'd3);
    blu_sel_i = mk_sel(8'h03, 4'd0, 5'd9);
    @(negedge clk_i);
    check("R6 zero length", {red_o, grn_o, blu_o, de_o}, {8'h01, 8'h02, 8'h03, 1'b1});

    // R5 length 15 equals length 8
    red_sel_i = mk_sel(8'h00, 4'd15, 5'd4);
    grn_sel_i = mk_sel(8'h00, 4'd9, 5'd0);
    blu_sel_i = mk_sel(8'h00, 4'd8, 5'd4);
    pix_i     = 32'h00000ABC;
    fmt_cfg_i = {27'd0, 2'd3, 3'd0};
    @(negedge clk_i);
    check("R5 clamp", {red_o, grn_o, blu_o, de_o}, {8'hAB, 8'hBC, 8'hAB, 1'b1});

    // R10 asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1;
    check("R10 async reset", {red_o, grn_o, blu_o, de_o}, 25'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule